// File: doc/BRIEF.md
# Serial Memory Status Register Engine

This block is the serial-slave front end of a small nonvolatile memory, limited to the status register path. It watches a mode-0 serial bus (chip select, serial clock, data in), decodes the instructions that touch status, and sends the status byte back on the data output. It keeps the busy flag and the write-enable latch, and holds the two block-protect bits. It decides whether write and status-write commands are accepted. When a command is accepted it starts an external write timer through a start/done handshake.

The protect bits have two copies. One is the stored value, which a status write loads when its internal cycle ends. The other is the value shown to the host. The shown copy is refreshed only when a status-read instruction is decoded while no cycle is running. As a result, a status read during a cycle keeps showing the old protect bits, while the busy and enable flags follow the internal state byte by byte. All pins are synchronised into the system clock domain. The serial clock must be several system clocks per half period.

Top module: `ssr_engine`

## Requirements
- R1: While chip select is low, data in is sampled MSB first on each rising serial clock edge. A frame acts only if chip select rises on a whole-byte boundary. A frame that ends mid-byte, even after a complete first byte, has no effect.
- R2: Opcode 0x05 (status read) makes the block drive the status byte, bit 7 first, changing on falling serial clock edges. It sends the status byte again and again for as long as chip select stays low.
- R3: The output enable `sdo_oe` is low while the instruction byte is shifting in and whenever chip select is high.
- R4: The status byte is laid out as follows: bit 0 is busy, bit 1 is the write-enable latch, bits 3:2 are the protect bits, and bits 7:4 read as 1.
- R5: A one-byte frame with opcode 0x06 sets the write-enable latch. A one-byte frame with opcode 0x04 clears it.
- R6: A status write (opcode 0x01 plus one data byte, exactly 16 bits) is ignored while the latch is 0 or busy is 1. The same holds for a write (opcode 0x02, three or more whole bytes).
- R7: An accepted write or status write pulses `wt_start` for one clock and sets busy. Busy stays set until `wt_done`, which then clears busy and the write-enable latch.
- R8: Hardware protection is active when `wp_n` is low and `nvlock_en` is high. While it is active, a status write starts no cycle, leaves the protect bits and the latch unchanged, and counts as ignored.
- R9: Data bits 3:2 of an accepted status write go into the stored protect bits when the cycle completes. The shown protect bits stay frozen until a status read is decoded with busy at 0. Busy and the latch are captured afresh at the start of every output byte.
- R10: After reset, busy and the latch are 0 and the protect bits equal `BP_INIT` (0 by default). `sdo_oe` and `wt_start` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock |
| mosi | input | 1 | Serial data in |
| wp_n | input | 1 | Write-protect pin, active low |
| nvlock_en | input | 1 | Static enable for hardware protection |
| wt_done | input | 1 | Write timer finished pulse |
| sdo | output | 1 | Serial data out value |
| sdo_oe | output | 1 | Output enable for the tri-state data out pad |
| wt_start | output | 1 | Write timer start pulse |

## Verification
Some rules are checked by assertions on every clock: the output stays disabled outside a read, a timer start only ever follows an enabled and idle state, and busy rises only together with a start. The same checks cover busy falling on a done pulse, the shown protect bits staying still for a whole cycle, and the stored bits changing only at completion. Other behaviour needs the bench's scenarios, because it involves whole transactions. This includes the exact status byte values, the repetition within one select period, and the mix within that repetition of frozen protect bits with live busy and latch bits. It also includes the sweep of every protect value against the write-protect pin and the lock enable, and the discarding of misaligned frames.

// File: rtl/ssr_pkg.sv
package ssr_pkg;
   localparam int BYTE_W = 8;
   localparam int BIT_W  = $clog2(BYTE_W);
   localparam int BC_W   = 2;

   typedef logic [BYTE_W-1:0] byte_t;
   typedef logic [BC_W-1:0]   bcnt_t;

   localparam bcnt_t BC_MAX = '1;

   localparam byte_t OP_WRSR  = 8'h01;
   localparam byte_t OP_WRITE = 8'h02;
   localparam byte_t OP_WRDI  = 8'h04;
   localparam byte_t OP_RDSR  = 8'h05;
   localparam byte_t OP_WREN  = 8'h06;

   typedef enum logic [2:0] {
      FR_NONE,
      FR_WREN,
      FR_WRDI,
      FR_WRSR,
      FR_WRITE
   } frame_kind_e;

   function automatic frame_kind_e classify(byte_t op, bcnt_t nb, logic aligned);
      frame_kind_e k;
      k = FR_NONE;
      if (aligned) begin
         if (nb == bcnt_t'(1) && op == OP_WREN)  k = FR_WREN;
         if (nb == bcnt_t'(1) && op == OP_WRDI)  k = FR_WRDI;
         if (nb == bcnt_t'(2) && op == OP_WRSR)  k = FR_WRSR;
         if (nb == BC_MAX     && op == OP_WRITE) k = FR_WRITE;
      end
      return k;
   endfunction
endpackage

// File: rtl/ssr_sync.sv
module ssr_sync #(
   parameter int          W       = 4,
   parameter int          STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [W-1:0] chain [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
            end else begin
               chain[0] <= d;
               for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
            end
         end
         assign q = chain[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/ssr_rx.sv
module ssr_rx import ssr_pkg::*; #(
   parameter int FIELD_LSB = 2,
   parameter int FIELD_W   = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sel,
   input  logic               sck_rise,
   input  logic               mosi_s,
   output byte_t              op,
   output logic               op_stb,
   output logic [FIELD_W-1:0] wr_field,
   output bcnt_t              nbytes,
   output logic               aligned
);
   logic [BIT_W-1:0]  bit_ph;
   logic [BYTE_W-2:0] sr;
   byte_t             rx_byte;

   assign rx_byte = {sr, mosi_s};
   assign aligned = (bit_ph == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_ph   <= '0;
         sr       <= '0;
         nbytes   <= '0;
         op       <= '0;
         op_stb   <= 1'b0;
         wr_field <= '0;
      end else if (!sel) begin
         bit_ph <= '0;
         nbytes <= '0;
         op_stb <= 1'b0;
      end else begin
         op_stb <= 1'b0;
         if (sck_rise) begin
            sr     <= rx_byte[BYTE_W-2:0];
            bit_ph <= bit_ph + 1'b1;
            if (bit_ph == BIT_W'(BYTE_W-1)) begin
               if (nbytes == bcnt_t'(0)) begin
                  op     <= rx_byte;
                  op_stb <= 1'b1;
               end else if (nbytes == bcnt_t'(1)) begin
                  wr_field <= rx_byte[FIELD_LSB +: FIELD_W];
               end
               if (nbytes != BC_MAX) nbytes <= nbytes + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/ssr_status.sv
module ssr_status import ssr_pkg::*; #(
   parameter int            BP_W    = 2,
   parameter logic [BP_W-1:0] BP_INIT = '0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            frame_end,
   input  frame_kind_e     kind,
   input  logic [BP_W-1:0] wr_bp,
   input  logic            rdsr_stb,
   input  logic            hpm,
   input  logic            wt_done,
   output logic            wip,
   output logic            wel,
   output logic [BP_W-1:0] bp_nv,
   output logic [BP_W-1:0] bp_view,
   output logic            wt_start,
   output byte_t           status
);
   localparam int FILL_W = BYTE_W - 2 - BP_W;

   logic [BP_W-1:0] bp_pend;
   logic            pend_v;
   logic            acc_wrsr, acc_write;

   assign acc_wrsr  = frame_end && (kind == FR_WRSR)  && wel && !wip && !hpm;
   assign acc_write = frame_end && (kind == FR_WRITE) && wel && !wip;

   generate
      if (FILL_W > 0) begin : g_fill
         assign status = {{FILL_W{1'b1}}, bp_view, wel, wip};
      end else begin : g_nofill
         assign status = {bp_view, wel, wip};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wip      <= 1'b0;
         wel      <= 1'b0;
         bp_nv    <= BP_INIT;
         bp_view  <= BP_INIT;
         bp_pend  <= '0;
         pend_v   <= 1'b0;
         wt_start <= 1'b0;
      end else begin
         wt_start <= acc_wrsr || acc_write;
         if (acc_wrsr) begin
            bp_pend <= wr_bp;
            pend_v  <= 1'b1;
         end
         if (acc_wrsr || acc_write) wip <= 1'b1;
         if (wip && wt_done) begin
            wip    <= 1'b0;
            wel    <= 1'b0;
            pend_v <= 1'b0;
            if (pend_v) bp_nv <= bp_pend;
         end
         if (frame_end && kind == FR_WREN) wel <= 1'b1;
         if (frame_end && kind == FR_WRDI) wel <= 1'b0;
         if (rdsr_stb && !wip) bp_view <= bp_nv;
      end
   end
endmodule

// File: rtl/ssr_tx.sv
module ssr_tx import ssr_pkg::*; (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  sel,
   input  logic  sck_fall,
   input  logic  rd_go,
   input  byte_t status,
   output logic  sdo,
   output logic  sdo_oe
);
   logic             rd_en;
   logic [BIT_W-1:0] left;
   logic [BYTE_W-2:0] sr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_en  <= 1'b0;
         sdo_oe <= 1'b0;
         sdo    <= 1'b0;
         left   <= '0;
         sr     <= '0;
      end else if (!sel) begin
         rd_en  <= 1'b0;
         sdo_oe <= 1'b0;
         sdo    <= 1'b0;
         left   <= '0;
      end else begin
         if (rd_go) rd_en <= 1'b1;
         if (rd_en && sck_fall) begin
            sdo_oe <= 1'b1;
            if (left == '0) begin
               sdo  <= status[BYTE_W-1];
               sr   <= status[BYTE_W-2:0];
               left <= BIT_W'(BYTE_W-1);
            end else begin
               sdo  <= sr[BYTE_W-2];
               sr   <= {sr[BYTE_W-3:0], 1'b0};
               left <= left - 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/ssr_engine.sv
module ssr_engine import ssr_pkg::*; #(
   parameter int              SYNC_STAGES = 2,
   parameter int              BP_W        = 2,
   parameter logic [BP_W-1:0] BP_INIT     = '0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_n,
   input  logic sck,
   input  logic mosi,
   input  logic wp_n,
   input  logic nvlock_en,
   input  logic wt_done,
   output logic sdo,
   output logic sdo_oe,
   output logic wt_start
);
   localparam int BP_LSB = 2;

   generate
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("ssr_engine: SYNC_STAGES must be 0..4");
      end
      if (BP_W < 1 || BP_W > BYTE_W - BP_LSB) begin : g_bad_bp
         $error("ssr_engine: BP_W out of range");
      end
   endgenerate

   logic [3:0]      pins_s;
   logic            cs_n_s, sck_s, mosi_s, wp_n_s;
   logic            sck_q, cs_q;
   logic            sck_rise, sck_fall, frame_end, hpm;
   byte_t           op;
   logic            op_stb, aligned;
   bcnt_t           nbytes;
   logic [BP_W-1:0] wr_bp;
   frame_kind_e     kind;
   logic            rdsr_stb;
   logic            wip, wel;
   logic [BP_W-1:0] bp_nv, bp_view;
   byte_t           status;

   ssr_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1001)) u_sync (
      .clk(clk), .rst_n(rst_n), .d({cs_n, sck, mosi, wp_n}), .q(pins_s));

   assign {cs_n_s, sck_s, mosi_s, wp_n_s} = pins_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_q <= 1'b0;
         cs_q  <= 1'b1;
      end else begin
         sck_q <= sck_s;
         cs_q  <= cs_n_s;
      end
   end

   assign sck_rise  = sck_s && !sck_q && !cs_n_s;
   assign sck_fall  = !sck_s && sck_q && !cs_n_s;
   assign frame_end = cs_n_s && !cs_q;
   assign hpm       = !wp_n_s && nvlock_en;
   assign kind      = classify(op, nbytes, aligned);
   assign rdsr_stb  = op_stb && (op == OP_RDSR);

   ssr_rx #(.FIELD_LSB(BP_LSB), .FIELD_W(BP_W)) u_rx (
      .clk(clk), .rst_n(rst_n), .sel(!cs_n_s), .sck_rise(sck_rise), .mosi_s(mosi_s),
      .op(op), .op_stb(op_stb), .wr_field(wr_bp), .nbytes(nbytes), .aligned(aligned));

   ssr_status #(.BP_W(BP_W), .BP_INIT(BP_INIT)) u_status (
      .clk(clk), .rst_n(rst_n), .frame_end(frame_end), .kind(kind), .wr_bp(wr_bp),
      .rdsr_stb(rdsr_stb), .hpm(hpm), .wt_done(wt_done), .wip(wip), .wel(wel),
      .bp_nv(bp_nv), .bp_view(bp_view), .wt_start(wt_start), .status(status));

   ssr_tx u_tx (
      .clk(clk), .rst_n(rst_n), .sel(!cs_n_s), .sck_fall(sck_fall), .rd_go(rdsr_stb),
      .status(status), .sdo(sdo), .sdo_oe(sdo_oe));
endmodule

// File: rtl/ssr_engine_chk.sv
module ssr_engine_chk #(
   parameter int BP_W = 2
) (
   input logic            clk,
   input logic            rst_n,
   input logic            cs_n_s,
   input logic            rd_en,
   input logic            sdo_oe,
   input logic            wip,
   input logic            wel,
   input logic            wt_start,
   input logic            wt_done,
   input logic [BP_W-1:0] bp_nv,
   input logic [BP_W-1:0] bp_view
);
   p_hiz_deselected_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_n_s && $past(cs_n_s)) |-> !sdo_oe);

   p_hiz_before_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |-> !sdo_oe);

   p_start_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wt_start |-> ($past(wel) && !$past(wip)));

   p_busy_with_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wip) |-> wt_start);

   p_busy_ends_on_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wip && wt_done) |=> !wip);

   p_view_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (wip && $past(wip)) |-> $stable(bp_view));

   p_store_on_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(bp_nv) |-> ($past(wip) && $past(wt_done)));
endmodule

bind ssr_engine ssr_engine_chk #(.BP_W(BP_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cs_n_s(cs_n_s), .rd_en(u_tx.rd_en), .sdo_oe(sdo_oe),
   .wip(wip), .wel(wel), .wt_start(wt_start), .wt_done(wt_done),
   .bp_nv(bp_nv), .bp_view(bp_view));

// File: tb/ssr_engine_tb_top.sv
module ssr_engine_tb_top;
   localparam int H     = 8;
   localparam int LIMIT = 150000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs_n = 1'b1, sck = 1'b0, mosi = 1'b0, wp_n = 1'b1, nvlock_en = 1'b0, wt_done = 1'b0;
   logic sdo, sdo_oe, wt_start;

   int nchk = 0, nerr = 0, start_cnt = 0, cyc = 0, hiz_bad = 0, oe_bad = 0;
   logic [7:0] rd_buf [4];
   logic [1:0] bp_exp;
   bit done_flag = 0;

   always #10 clk = ~clk;

   ssr_engine dut_i (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi), .wp_n(wp_n),
      .nvlock_en(nvlock_en), .wt_done(wt_done), .sdo(sdo), .sdo_oe(sdo_oe),
      .wt_start(wt_start));

   always @(posedge clk) begin
      if (rst_n && wt_start) start_cnt <= start_cnt + 1;
      cyc <= cyc + 1;
      if (cyc == LIMIT && !done_flag) begin
         nerr = nerr + 1;
         nchk = nchk + 1;
         $display("FAIL watchdog: actual=%0d expected<%0d cycles", cyc, LIMIT);
         $display("  Result: errors=%0d of %0d checks", nerr, nchk);
         $finish;
      end
   end

   task automatic hold(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] stat(input logic [1:0] bp, input logic wl, input logic wp);
      return {4'hF, bp, wl, wp};
   endfunction

   task automatic shift_bits(input logic [31:0] bits, input int n);
      for (int i = n - 1; i >= 0; i--) begin
         mosi = bits[i];
         hold(H);
         sck = 1'b1;
         hold(H);
         if (sdo_oe) hiz_bad++;
         sck = 1'b0;
      end
   endtask

   task automatic frame(input logic [31:0] bits, input int n);
      cs_n = 1'b0;
      hold(H);
      shift_bits(bits, n);
      hold(H);
      cs_n = 1'b1;
      hold(3 * H);
   endtask

   task automatic pulse_done();
      wt_done = 1'b1;
      hold(1);
      wt_done = 1'b0;
   endtask

   // reads nb status bytes; pulses the timer done after byte done_at
   task automatic rdsr(input int nb, input int done_at);
      cs_n = 1'b0;
      hold(H);
      shift_bits(32'h05, 8);
      for (int b = 0; b < nb; b++) begin
         for (int k = 7; k >= 0; k--) begin
            hold(H);
            rd_buf[b][k] = sdo;
            if (!sdo_oe) oe_bad++;
            if (b == done_at && k == 0) pulse_done();
            sck = 1'b1;
            hold(H);
            sck = 1'b0;
         end
      end
      hold(H);
      cs_n = 1'b1;
      hold(3 * H);
   endtask

   initial begin
      int s0;
      logic acc;
      hold(5);
      rst_n = 1'b1;
      hold(5);
      check("R10 reset sdo_oe", {31'd0, sdo_oe}, 0);
      check("R10 reset wt_start", {31'd0, wt_start}, 0);
      rdsr(1, -1);
      check("R10 R4 reset status", rd_buf[0], stat(2'd0, 0, 0));
      check("R3 hi-Z during instruction", hiz_bad, 0);
      bp_exp = 2'd0;

      frame(32'h06, 8);
      rdsr(1, -1);
      check("R5 write enable sets latch", rd_buf[0], stat(bp_exp, 1, 0));
      frame(32'h04, 8);
      rdsr(1, -1);
      check("R5 write disable clears latch", rd_buf[0], stat(bp_exp, 0, 0));

      frame(32'h010C, 16);
      check("R6 status write without latch starts nothing", start_cnt, 0);
      rdsr(1, -1);
      check("R6 status unchanged", rd_buf[0], stat(bp_exp, 0, 0));

      frame(32'h065, 12);
      rdsr(1, -1);
      check("R1 misaligned enable ignored", rd_buf[0], stat(bp_exp, 0, 0));

      frame(32'h06, 8);
      rdsr(3, -1);
      for (int b = 0; b < 3; b++) check("R2 repeated status byte", rd_buf[b], stat(bp_exp, 1, 0));
      check("R2 output enabled during read", oe_bad, 0);
      frame(32'h04, 8);

      for (int v = 0; v < 4; v++) begin
         for (int w = 0; w < 2; w++) begin
            for (int l = 0; l < 2; l++) begin
               wp_n = w[0];
               nvlock_en = l[0];
               hold(2 * H);
               frame(32'h06, 8);
               s0 = start_cnt;
               frame({16'd0, 8'h01, 4'h0, v[1:0], 2'b00}, 16);
               acc = !(w == 0 && l == 1);
               check("R8 R7 status write start", start_cnt - s0, {31'd0, acc});
               if (acc) begin
                  rdsr(1, -1);
                  check("R9 protect bits frozen while busy", rd_buf[0], stat(bp_exp, 1, 1));
                  frame(32'h06, 8);
                  frame({16'd0, 8'h01, 4'h0, ~v[1:0], 2'b00}, 16);
                  check("R6 status write while busy rejected", start_cnt - s0, 1);
                  rdsr(2, 0);
                  check("R9 byte before done", rd_buf[0], stat(bp_exp, 1, 1));
                  check("R9 live flags, frozen protect", rd_buf[1], stat(bp_exp, 0, 0));
                  bp_exp = v[1:0];
                  rdsr(1, -1);
                  check("R9 new protect after cycle", rd_buf[0], stat(bp_exp, 0, 0));
               end else begin
                  rdsr(1, -1);
                  check("R8 protected, bits and latch kept", rd_buf[0], stat(bp_exp, 1, 0));
                  frame(32'h04, 8);
               end
            end
         end
      end
      wp_n = 1'b1;
      nvlock_en = 1'b0;
      hold(2 * H);

      s0 = start_cnt;
      frame(32'h0200AA, 24);
      check("R6 write without latch ignored", start_cnt - s0, 0);
      frame(32'h06, 8);
      frame(32'h0200AA, 24);
      check("R7 write accepted", start_cnt - s0, 1);
      rdsr(1, -1);
      check("R7 busy during write", rd_buf[0], stat(bp_exp, 1, 1));
      pulse_done();
      hold(H);
      rdsr(1, -1);
      check("R7 done clears busy and latch", rd_buf[0], stat(bp_exp, 0, 0));

      frame(32'h06, 8);
      s0 = start_cnt;
      frame(32'h0200, 16);
      check("R6 short write ignored", start_cnt - s0, 0);
      frame({15'd0, 8'h01, 8'h00, 1'b0}, 17);
      check("R1 misaligned status write ignored", start_cnt - s0, 0);
      rdsr(1, -1);
      check("R1 status after misaligned frames", rd_buf[0], stat(bp_exp, 1, 0));
      check("R3 hi-Z on every instruction bit", hiz_bad, 0);
      check("R3 output off when deselected", {31'd0, sdo_oe}, 0);

      done_flag = 1;
      $display("  Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end
endmodule